// File: doc/BRIEF.md
# Clock-Recovery Event Status Register

This block is a 16-bit memory-mapped status word that gathers sticky event flags from the clock-recovery logic. Seven sources feed it: a reference-clock failure detector, the SRTS transmit and receive slip detectors (underrun and overrun for each direction), a loss-of-timing-reference detector and the timing-reference sync state machine. Each event is latched into its own flag. Software reads the word and clears flags by writing ones over them.

A summary bit at the top of the word is set whenever any flag is set. The flags also drive two qualified outputs. The first is a freerun request, raised when the reference has failed and a 2-bit mode selects that behaviour. The second is a timing-service request, raised when the out-of-sync flag is set and its interrupt enable is on. A test control forces every flag to one so that the software path can be exercised without real events.

Top module: `clkstat_reg`

## Requirements
- R1: After synchronous reset, rd_data reads 0x0000 and freerun_o and tim_serv_o are 0.
- R2: A one-cycle pulse on an event input sets its flag at the next clock edge, and the flag stays set until it is cleared. The bit positions are: reference failure at 0, transmit underrun at 1, transmit overrun at 2, receive underrun at 3, receive overrun at 4, timing-reference loss at 5, and out-of-sync at 6.
- R3: A write (wr_en=1) clears each flag whose wr_data bit is 1. Flags whose wr_data bit is 0 are left unchanged.
- R4: Bits 14 to 7 of rd_data always read 0.
- R5: Bit 15 of rd_data is 1 exactly when any of bits 6 to 0 is 1.
- R6: The out-of-sync flag sets on the second clock edge after sync_lost_lvl rises. While the level stays high, it is never set again, even after it has been cleared.
- R7: A timing-reference loss pulse sets bit 5 only when tim_ena is 1 in the same cycle.
- R8: A cycle with test_force=1 sets all of bits 6 to 0 at the next edge. The flags stay set after test_force falls, until they are cleared.
- R9: freerun_o is 1 exactly when bit 0 is set and freerun_mode equals 2'b01.
- R10: tim_serv_o is 1 exactly when bit 6 is set and oos_irq_en is 1.
- R11: If a hardware set and a write-one-to-clear reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Write data; a 1 in bits 6:0 clears that flag |
| rd_data | output | 16 | Current status word |
| ref_fail_evt | input | 1 | Reference-clock failure pulse |
| tx_under_evt | input | 1 | SRTS transmit underrun pulse |
| tx_over_evt | input | 1 | SRTS transmit overrun pulse |
| rx_under_evt | input | 1 | SRTS receive underrun pulse |
| rx_over_evt | input | 1 | SRTS receive overrun pulse |
| tref_loss_evt | input | 1 | Timing-reference loss pulse |
| sync_lost_lvl | input | 1 | Level from the sync state machine, high while out of sync |
| tim_ena | input | 1 | Timing-reference receive enable |
| test_force | input | 1 | Test control that forces all flags |
| oos_irq_en | input | 1 | Out-of-sync service enable |
| freerun_mode | input | 2 | Freerun mode field; 2'b01 allows freerun |
| freerun_o | output | 1 | External freerun request |
| tim_serv_o | output | 1 | Timing-service request |

## Verification
On every cycle, the assertions check that the reserved bits stay zero, that the summary bit tracks the flags, and that both qualified outputs follow their flag and control. They also check that a cleared flag with no competing set drops, that a set always lands, that the sync edge detector never pulses twice in a row, and that a loss flag never rises without the enable. Only the bench scenarios can show the multi-cycle stories. These are the two-edge latency of the out-of-sync flag and its refusal to re-arm while the level stays high, the persistence of forced flags after test mode ends, and the exhaustive sweep of clear masks over a fully set word.

// File: rtl/clkstat_pkg.sv
package clkstat_pkg;

    localparam int REG_W     = 16;
    localparam int NUM_FLAGS = 7;
    localparam int SUM_BIT   = REG_W - 1;
    localparam int RSV_LO    = NUM_FLAGS;
    localparam int RSV_HI    = SUM_BIT - 1;

    // flag positions; software decodes these
    localparam int FLG_REF   = 0;
    localparam int FLG_TXUND = 1;
    localparam int FLG_TXOVR = 2;
    localparam int FLG_RXUND = 3;
    localparam int FLG_RXOVR = 4;
    localparam int FLG_LOSS  = 5;
    localparam int FLG_OOS   = 6;

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
    typedef logic [REG_W-1:0]     word_t;

    typedef enum logic [1:0] {
        FR_OFF   = 2'b00,
        FR_ARMED = 2'b01,
        FR_RSV2  = 2'b10,
        FR_RSV3  = 2'b11
    } freerun_mode_e;

    typedef struct packed {
        logic ref_fail;
        logic tx_under;
        logic tx_over;
        logic rx_under;
        logic rx_over;
        logic tref_loss;
    } evt_in_t;

    typedef struct packed {
        logic tim_ena;
        logic test_force;
        logic oos_irq_en;
        freerun_mode_e mode;
    } ctrl_t;

    function automatic word_t pack_word(input flag_vec_t f);
        word_t w;
        w = '0;
        w[NUM_FLAGS-1:0] = f;
        w[SUM_BIT]       = |f;
        return w;
    endfunction

endpackage

// File: rtl/clkstat_edge_det.sv
module clkstat_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic rise_o
);
    logic samp_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            samp_q <= lvl_in;
            prev_q <= samp_q;
        end
    end

    assign rise_o = samp_q & ~prev_q;

    // R6: entry into out-of-sync yields isolated single-cycle pulses
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/clkstat_flag_cell.sv
module clkstat_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;

    a_r11_set_lands: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);

    a_r3_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);

    a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
        (q_o && !clr_i) |=> q_o);

endmodule

// File: rtl/clkstat_flag_bank.sv
module clkstat_flag_bank
    import clkstat_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         force_i,
    output logic [N-1:0] flags_o
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        logic set_eff;
        assign set_eff = set_i[i] | force_i;
        clkstat_flag_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_eff),
            .clr_i (clr_i[i]),
            .q_o   (flags_o[i])
        );
    end

    // R8: a forcing cycle fills the whole bank
    a_r8_force_fills: assert property (@(posedge clk) disable iff (rst)
        force_i |=> (&flags_o));

endmodule

// File: rtl/clkstat_reg.sv
module clkstat_reg
    import clkstat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        ref_fail_evt,
    input  logic        tx_under_evt,
    input  logic        tx_over_evt,
    input  logic        rx_under_evt,
    input  logic        rx_over_evt,
    input  logic        tref_loss_evt,
    input  logic        sync_lost_lvl,
    input  logic        tim_ena,
    input  logic        test_force,
    input  logic        oos_irq_en,
    input  logic [1:0]  freerun_mode,
    output logic        freerun_o,
    output logic        tim_serv_o
);
    evt_in_t   evt;
    ctrl_t     ctl;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags;
    logic      oos_rise;
    logic      unused_wr_hi;

    assign evt = '{ref_fail:  ref_fail_evt,
                   tx_under:  tx_under_evt,
                   tx_over:   tx_over_evt,
                   rx_under:  rx_under_evt,
                   rx_over:   rx_over_evt,
                   tref_loss: tref_loss_evt};

    assign ctl = '{tim_ena:    tim_ena,
                   test_force: test_force,
                   oos_irq_en: oos_irq_en,
                   mode:       freerun_mode_e'(freerun_mode)};

    clkstat_edge_det u_oos_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (sync_lost_lvl),
        .rise_o (oos_rise)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FLG_REF]   = evt.ref_fail;
        set_vec[FLG_TXUND] = evt.tx_under;
        set_vec[FLG_TXOVR] = evt.tx_over;
        set_vec[FLG_RXUND] = evt.rx_under;
        set_vec[FLG_RXOVR] = evt.rx_over;
        set_vec[FLG_LOSS]  = evt.tref_loss & ctl.tim_ena;
        set_vec[FLG_OOS]   = oos_rise;
    end

    assign clr_vec      = wr_en ? wr_data[NUM_FLAGS-1:0] : '0;
    assign unused_wr_hi = ^wr_data[REG_W-1:NUM_FLAGS];

    clkstat_flag_bank #(.N(NUM_FLAGS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_i   (set_vec),
        .clr_i   (clr_vec),
        .force_i (ctl.test_force),
        .flags_o (flags)
    );

    assign rd_data    = pack_word(flags);
    assign freerun_o  = flags[FLG_REF] && (ctl.mode == FR_ARMED);
    assign tim_serv_o = flags[FLG_OOS] && ctl.oos_irq_en;

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[RSV_HI:RSV_LO] == '0);

    a_r5_summary_tracks: assert property (@(posedge clk) disable iff (rst)
        rd_data[SUM_BIT] == (rd_data[NUM_FLAGS-1:0] != '0));

    a_r9_freerun_qual: assert property (@(posedge clk) disable iff (rst)
        freerun_o == (rd_data[FLG_REF] && freerun_mode == 2'b01));

    a_r10_serv_qual: assert property (@(posedge clk) disable iff (rst)
        tim_serv_o == (rd_data[FLG_OOS] && oos_irq_en));

    a_r7_loss_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[FLG_LOSS] && !tim_ena && !test_force) |=> !rd_data[FLG_LOSS]);

endmodule

// File: tb/test_clkstat_reg.sv
module test_clkstat_reg;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic        ref_fail_evt, tx_under_evt, tx_over_evt;
    logic        rx_under_evt, rx_over_evt, tref_loss_evt;
    logic        sync_lost_lvl, tim_ena, test_force, oos_irq_en;
    logic [1:0]  freerun_mode;
    logic        freerun_o, tim_serv_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    clkstat_reg i_clkstat_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ref_fail_evt(ref_fail_evt), .tx_under_evt(tx_under_evt), .tx_over_evt(tx_over_evt),
        .rx_under_evt(rx_under_evt), .rx_over_evt(rx_over_evt), .tref_loss_evt(tref_loss_evt),
        .sync_lost_lvl(sync_lost_lvl), .tim_ena(tim_ena), .test_force(test_force),
        .oos_irq_en(oos_irq_en), .freerun_mode(freerun_mode),
        .freerun_o(freerun_o), .tim_serv_o(tim_serv_o)
    );

    function automatic logic [15:0] expect_word(input logic [6:0] f);
        return {(f != 7'd0), 8'd0, f};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_evt(input int idx);
        case (idx)
            0: ref_fail_evt  = 1'b1;
            1: tx_under_evt  = 1'b1;
            2: tx_over_evt   = 1'b1;
            3: rx_under_evt  = 1'b1;
            4: rx_over_evt   = 1'b1;
            5: tref_loss_evt = 1'b1;
            default: ;
        endcase
        step();
        {ref_fail_evt, tx_under_evt, tx_over_evt, rx_under_evt, rx_over_evt, tref_loss_evt} = '0;
    endtask

    task automatic wr(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic fill_all();
        test_force = 1'b1;
        step();
        test_force = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0;
        {ref_fail_evt, tx_under_evt, tx_over_evt, rx_under_evt, rx_over_evt, tref_loss_evt} = '0;
        sync_lost_lvl = 1'b0; tim_ena = 1'b1; test_force = 1'b0; oos_irq_en = 1'b1;
        freerun_mode = 2'b01;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 word", rd_data, 16'h0000);
        chk("R1 outputs", {14'd0, freerun_o, tim_serv_o}, 16'h0000);

        // R2/R5 each event alone sets only its bit; R3 one-hot clear removes it
        for (int i = 0; i < 6; i++) begin
            pulse_evt(i);
            chk("R2 set", rd_data, expect_word(7'(1 << i)));
            step();
            chk("R2 sticky", rd_data, expect_word(7'(1 << i)));
            wr(16'(~(1 << i)) & 16'h007F);
            chk("R3 zero-bits keep", rd_data, expect_word(7'(1 << i)));
            wr(16'(1 << i));
            chk("R3 clear", rd_data, 16'h0000);
        end

        // R7 loss gated by enable
        tim_ena = 1'b0;
        pulse_evt(5);
        chk("R7 gated off", rd_data, 16'h0000);
        tim_ena = 1'b1;
        pulse_evt(5);
        chk("R7 enabled", rd_data, expect_word(7'h20));
        wr(16'h0020);

        // R6 out-of-sync edge latency and no re-arm
        sync_lost_lvl = 1'b1;
        step();
        chk("R6 not yet", rd_data, 16'h0000);
        step();
        chk("R6 set", rd_data, expect_word(7'h40));
        // R10 service output
        chk("R10 ie=1", {15'd0, tim_serv_o}, 16'h0001);
        oos_irq_en = 1'b0; #1;
        chk("R10 ie=0", {15'd0, tim_serv_o}, 16'h0000);
        oos_irq_en = 1'b1;
        wr(16'h0040);
        repeat (5) step();
        chk("R6 no re-arm while held", rd_data, 16'h0000);
        sync_lost_lvl = 1'b0;
        repeat (3) step();
        sync_lost_lvl = 1'b1;
        repeat (2) step();
        chk("R6 new entry", rd_data, expect_word(7'h40));
        sync_lost_lvl = 1'b0;
        wr(16'h0040);
        chk("R10 flag clear", {15'd0, tim_serv_o}, 16'h0000);

        // R11 set beats clear
        ref_fail_evt = 1'b1; wr_en = 1'b1; wr_data = 16'h0001;
        step();
        ref_fail_evt = 1'b0; wr_en = 1'b0; wr_data = '0;
        chk("R11 set wins", rd_data, expect_word(7'h01));

        // R9 freerun sweep
        for (int m = 0; m < 4; m++) begin
            freerun_mode = 2'(m); #1;
            chk("R9 flag=1", {15'd0, freerun_o}, {15'd0, (m == 1)});
        end
        wr(16'h0001);
        for (int m = 0; m < 4; m++) begin
            freerun_mode = 2'(m); #1;
            chk("R9 flag=0", {15'd0, freerun_o}, 16'h0000);
        end

        // R8 test force fills, persists, and holds against clears while high
        test_force = 1'b1;
        step();
        chk("R8 forced", rd_data, 16'h807F);
        wr(16'hFFFF);
        chk("R8 held", rd_data, 16'h807F);
        test_force = 1'b0;
        step();
        chk("R8 persists", rd_data, 16'h807F);

        // R3/R4/R5 exhaustive clear masks, upper write bits random junk
        for (int m = 0; m < 128; m++) begin
            fill_all();
            wr({9'(m * 37 + 5), 7'(m)});
            chk("R3 R4 R5 mask sweep", rd_data, expect_word(7'h7F & ~7'(m)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule